// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core that executes one instruction per clock period. The current program counter leaves the core on `pc_o`. An instruction memory outside the core returns the word at that address on `instr_i`. Between two rising edges the core decodes the word, reads its operands, computes through the ALU, reads or writes the data memory and prepares the write-back value and the next program counter. The rising edge commits the register write, the memory write and the new program counter together.

Only ten instructions are understood:
- add, subtract, AND, OR and signed set-on-less-than between registers;
- word load and word store;
- branch-if-equal;
- add-immediate;
- unconditional jump.

The ALU result is brought out on `alu_res_o`, so software running on the core can be traced from outside through the program counter and the ALU result. The register file, data memory and decode logic stay internal.

Top module: `scpu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter becomes 0 and all 32 registers become 0. Data memory is not cleared.
- R2: Any instruction other than a taken branch or a jump moves `pc_o` to `pc_o + 4` at the next rising edge. An unrecognised instruction writes nothing.
- R3: Register-register instructions use opcode 000000 and take the operation from bits [5:0]: 100000 add, 100010 subtract, 100100 AND, 100101 OR. Field rs is [25:21], rt is [20:16] and rd is [15:11]. `alu_res_o` shows rs op rt in the same cycle, and the result is written to rd at the edge.
- R4: Function 101010 (set-on-less-than) compares rs and rt as signed numbers. It shows and writes 1 when rs < rt and 0 otherwise.
- R5: Add-immediate (opcode 001000) shows rs plus the sign-extended bits [15:0] and writes that sum to rt.
- R6: Store (opcode 101011) and load (opcode 100011) show the address rs + sign-extended immediate on `alu_res_o`. The word is selected by address bits [7:2]. A store writes rt at the edge. A load writes the stored word to rt.
- R7: Branch-if-equal (opcode 000100) shows rs − rt. When that is zero, the next PC is PC + 4 + (sign-extended immediate × 4). Otherwise the next PC is PC + 4.
- R8: Jump (opcode 000010) sets the next PC to bits [31:28] of PC + 4 joined with bits [25:0] of the instruction and two zero bits.
- R9: Register 0 always reads as 0. A write that targets it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_o | output | 32 | Address of the instruction being executed |
| instr_i | input | 32 | Instruction word fetched from `pc_o` |
| alu_res_o | output | 32 | ALU result of the current instruction |

## Verification
`alu_res_o` is combinational from `instr_i` and the register state. The bench therefore drives each instruction just after a falling edge and checks the ALU result one nanosecond later, inside that same cycle. Register and memory writes, along with the new program counter, become visible one rising edge later. They are checked through the next instruction's `pc_o` and through the ALU result of a later instruction that reads the written register. The checker compares each next-PC rule against the program counter and instruction from one edge earlier.

// File: rtl/scpu_pkg.sv
// Package: instruction encodings, ALU operation codes and the decoded
// control bundle shared by the core's sub-modules.
// Assumes a fixed 32-bit instruction word with 6-bit opcode and function.
package scpu_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_ADDI  = 6'b001000;
    localparam logic [5:0] OP_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;   // write-back enabled
        logic    dst_is_rd;   // destination is rd (else rt)
        logic    src_imm;     // second ALU operand is the immediate
        logic    mem_write;   // store to data memory
        logic    mem_to_reg;  // write-back takes the memory word
        logic    branch;      // branch-if-equal
        logic    jump;        // unconditional jump
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/scpu_decode.sv
// Decoder: maps opcode and function fields onto the control bundle.
// Assumes unrecognised encodings must have no architectural effect, so
// they decode to an all-inactive bundle (the PC still advances by 4).
module scpu_decode
    import scpu_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output ctrl_t      ctrl_o
);

    // Purpose: combine main decode and ALU-operation decode.
    always_comb begin
        ctrl_o = '0;
        ctrl_o.alu_op = ALU_ADD;
        unique case (opcode_i)
            OP_RTYPE: begin
                ctrl_o.dst_is_rd = 1'b1;
                ctrl_o.reg_write = 1'b1;
                unique case (funct_i)
                    FN_ADD:  ctrl_o.alu_op = ALU_ADD;
                    FN_SUB:  ctrl_o.alu_op = ALU_SUB;
                    FN_AND:  ctrl_o.alu_op = ALU_AND;
                    FN_OR:   ctrl_o.alu_op = ALU_OR;
                    FN_SLT:  ctrl_o.alu_op = ALU_SLT;
                    default: ctrl_o.reg_write = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctrl_o.reg_write  = 1'b1;
                ctrl_o.src_imm    = 1'b1;
                ctrl_o.mem_to_reg = 1'b1;
            end
            OP_STORE: begin
                ctrl_o.src_imm   = 1'b1;
                ctrl_o.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctrl_o.branch = 1'b1;
                ctrl_o.alu_op = ALU_SUB;
            end
            OP_ADDI: begin
                ctrl_o.reg_write = 1'b1;
                ctrl_o.src_imm   = 1'b1;
            end
            OP_JUMP: begin
                ctrl_o.jump = 1'b1;
            end
            default: ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/scpu_regfile.sv
// Register file: two combinational read ports, one write port committed
// on the rising edge. Assumes entry 0 is hard-wired to zero; a write
// addressed to it is dropped. Synchronous active-low reset clears all.
module scpu_regfile #(
    parameter int NREGS = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ra_addr_i,
    input  logic [AW-1:0]    rb_addr_i,
    output logic [WIDTH-1:0] ra_data_o,
    output logic [WIDTH-1:0] rb_data_o,
    input  logic             we_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [WIDTH-1:0] wr_data_i
);

    logic [WIDTH-1:0] regs_q [NREGS];

    // Purpose: reset or write one register per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we_i && (wr_addr_i != '0)) begin
            regs_q[wr_addr_i] <= wr_data_i;
        end
    end

    // Purpose: asynchronous reads with entry 0 forced to zero.
    always_comb begin
        ra_data_o = (ra_addr_i == '0) ? '0 : regs_q[ra_addr_i];
        rb_data_o = (rb_addr_i == '0) ? '0 : regs_q[rb_addr_i];
    end

endmodule

// File: rtl/scpu_alu.sv
// ALU: add, subtract, AND, OR and signed set-on-less-than, plus a zero
// flag used by the branch comparison. Purely combinational.
module scpu_alu
    import scpu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] y_o,
    output logic             zero_o
);

    // Purpose: select the operation result.
    always_comb begin
        unique case (op_i)
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_SLT: y_o = {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            default: y_o = '0;
        endcase
    end

    // Purpose: flag an all-zero result.
    assign zero_o = (y_o == '0);

endmodule

// File: rtl/scpu_dmem.sv
// Data memory: word array, combinational read, write on the rising edge.
// Assumes the caller supplies a word index (byte address bits above 1);
// contents are not cleared by reset.
module scpu_dmem #(
    parameter int WORDS = 64,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic [AW-1:0]    idx_i,
    input  logic             we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] mem_q [WORDS];

    // Purpose: commit a store.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[idx_i] <= wdata_i;
    end

    // Purpose: asynchronous word read.
    assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/scpu_core.sv
// Top: single-cycle core. One instruction per clock; fetch, decode,
// execute, memory and write-back settle between rising edges. Assumes
// the instruction arrives on instr_i as a function of pc_o within the
// same cycle. Synchronous active-low reset returns the PC to 0.
module scpu_core
    import scpu_pkg::*;
#(
    parameter int DMEM_WORDS = 64,
    parameter int NREGS      = 32,
    localparam int RAW       = $clog2(NREGS),
    localparam int DAW       = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] pc_o,
    input  logic [XLEN-1:0] instr_i,
    output logic [XLEN-1:0] alu_res_o
);

    logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_target, jmp_target;
    logic [XLEN-1:0] imm_sext, rs_val, rt_val, alu_b, wb_data, mem_rdata;
    logic [RAW-1:0]  wr_addr;
    logic            alu_zero;
    logic            unused_bits;
    ctrl_t           ctrl;

    assign unused_bits = ^instr_i[10:6];

    scpu_decode u_dec (
        .opcode_i (instr_i[31:26]),
        .funct_i  (instr_i[5:0]),
        .ctrl_o   (ctrl)
    );

    // Purpose: sign extension and operand selection.
    always_comb begin
        imm_sext = {{(XLEN-16){instr_i[15]}}, instr_i[15:0]};
        alu_b    = ctrl.src_imm ? imm_sext : rt_val;
        wr_addr  = ctrl.dst_is_rd ? instr_i[11+RAW-1:11] : instr_i[16+RAW-1:16];
        wb_data  = ctrl.mem_to_reg ? mem_rdata : alu_res_o;
    end

    scpu_regfile #(.NREGS(NREGS), .WIDTH(XLEN)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ra_addr_i (instr_i[21+RAW-1:21]),
        .rb_addr_i (instr_i[16+RAW-1:16]),
        .ra_data_o (rs_val),
        .rb_data_o (rt_val),
        .we_i      (ctrl.reg_write),
        .wr_addr_i (wr_addr),
        .wr_data_i (wb_data)
    );

    scpu_alu #(.WIDTH(XLEN)) u_alu (
        .op_i   (ctrl.alu_op),
        .a_i    (rs_val),
        .b_i    (alu_b),
        .y_o    (alu_res_o),
        .zero_o (alu_zero)
    );

    scpu_dmem #(.WORDS(DMEM_WORDS), .WIDTH(XLEN)) u_dmem (
        .clk     (clk),
        .idx_i   (alu_res_o[DAW+1:2]),
        .we_i    (ctrl.mem_write),
        .wdata_i (rt_val),
        .rdata_o (mem_rdata)
    );

    // Purpose: next-PC selection among sequential, branch and jump.
    always_comb begin
        pc_plus4   = pc_q + 32'd4;
        br_target  = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
        jmp_target = {pc_plus4[31:28], instr_i[25:0], 2'b00};
        if (ctrl.jump)                    pc_next = jmp_target;
        else if (ctrl.branch && alu_zero) pc_next = br_target;
        else                              pc_next = pc_plus4;
    end

    // Purpose: program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/scpu_core_chk.sv
// Checker: next-PC and reset properties of the core, observed at its ports.
module scpu_core_chk
    import scpu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] instr_i,
    input logic [XLEN-1:0] alu_res_o
);

    logic [5:0]      opc;
    logic [XLEN-1:0] br_ofs;
    assign opc    = instr_i[31:26];
    assign br_ofs = {{(XLEN-18){instr_i[15]}}, instr_i[15:0], 2'b00};

    AST_RESET_PC: assert property (@(posedge clk)
        !rst_n |=> pc_o == '0); // R1

    AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OP_BEQ && opc != OP_JUMP) |=> pc_o == $past(pc_o) + 32'd4); // R2

    AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_RTYPE && instr_i[5:0] == FN_SLT) |-> alu_res_o[XLEN-1:1] == '0); // R4

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_BEQ && alu_res_o == '0) |=>
        pc_o == $past(pc_o) + 32'd4 + $past(br_ofs)); // R7

    AST_BEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_BEQ && alu_res_o != '0) |=> pc_o == $past(pc_o) + 32'd4); // R7

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        opc == OP_JUMP |=>
        pc_o == {$past(pc_o[31:28] + {3'b000, &pc_o[27:2]}), $past(instr_i[25:0]), 2'b00}); // R8

endmodule

bind scpu_core scpu_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_o      (pc_o),
    .instr_i   (instr_i),
    .alu_res_o (alu_res_o)
);

// File: tb/scpu_core_test.sv
`timescale 1ns/1ps
module scpu_core_test;

    localparam logic [5:0] OPR = 6'b000000, OPL = 6'b100011, OPS = 6'b101011;
    localparam logic [5:0] OPB = 6'b000100, OPI = 6'b001000, OPJ = 6'b000010;
    localparam logic [5:0] FADD = 6'b100000, FSUB = 6'b100010, FAND = 6'b100100;
    localparam logic [5:0] FOR  = 6'b100101, FSLT = 6'b101010;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {OPR, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int tgt);
        return {OPJ, 26'(tgt)};
    endfunction

    // Vector: {check_alu, instruction, expected pc, expected alu result}
    localparam int NV = 18;
    localparam logic [96:0] VEC [NV] = '{
        {1'b1, enc_i(OPI, 0, 1, 5),      32'd0,  32'd5},          // R5
        {1'b1, enc_i(OPI, 0, 2, -3),     32'd4,  32'hFFFF_FFFD},  // R5 negative
        {1'b1, enc_r(1, 2, 3, FADD),     32'd8,  32'd2},          // R3 add
        {1'b1, enc_r(1, 2, 4, FSUB),     32'd12, 32'd8},          // R3 sub
        {1'b1, enc_r(1, 4, 5, FOR),      32'd16, 32'd13},         // R3 or
        {1'b1, enc_r(5, 1, 6, FAND),     32'd20, 32'd5},          // R3 and
        {1'b1, enc_r(2, 1, 7, FSLT),     32'd24, 32'd1},          // R4 -3<5
        {1'b1, enc_r(1, 2, 8, FSLT),     32'd28, 32'd0},          // R4 5<-3
        {1'b1, enc_i(OPS, 1, 5, 7),      32'd32, 32'd12},         // R6 store
        {1'b1, enc_i(OPL, 0, 9, 12),     32'd36, 32'd12},         // R6 load
        {1'b1, enc_i(OPI, 0, 0, 7),      32'd40, 32'd7},          // R9 write r0
        {1'b1, enc_r(0, 9, 10, FADD),    32'd44, 32'd13},         // R9 + R6 data
        {1'b1, enc_i(OPB, 1, 9, 5),      32'd48, 32'hFFFF_FFF8},  // R7 not taken
        {1'b1, enc_i(OPB, 6, 1, 2),      32'd52, 32'd0},          // R7 taken fwd
        {1'b0, enc_j(20),                32'd64, 32'd0},          // R8 jump
        {1'b1, enc_i(OPB, 0, 0, -4),     32'd80, 32'd0},          // R7 taken back
        {1'b1, enc_i(OPI, 10, 11, -20),  32'd68, 32'hFFFF_FFF9},  // R5
        {1'b1, enc_r(7, 8, 12, FSUB),    32'd72, 32'd1}           // R3 rd write
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc, alu;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    scpu_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_o      (pc),
        .instr_i   (instr),
        .alu_res_o (alu)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one instruction after a falling edge, check, then cross an edge.
    task automatic step(string req, logic [31:0] ins, logic [31:0] epc,
                        logic [31:0] ealu, bit chk_alu);
        instr = ins;
        #1;
        check({req, " pc"}, pc, epc);
        if (chk_alu) check({req, " alu"}, alu, ealu);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", pc, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++)
            step("R2..R9 vector", VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], VEC[i][96]);
        #1 check("R2 pc after table", pc, 32'd76);

        // Mid-run reset clears PC and registers.
        rst_n = 1'b0;
        instr = enc_r(1, 1, 1, FADD);
        @(posedge clk);
        @(negedge clk);
        check("R1 pc after reset", pc, 32'd0);
        rst_n = 1'b1;
        step("R1 regs cleared", enc_r(10, 11, 13, FADD), 32'd0, 32'd0, 1'b1);
        step("R5 min imm", enc_i(OPI, 0, 1, -32768), 32'd4, 32'hFFFF_8000, 1'b1);
        step("R4 signed slt", enc_r(1, 0, 2, FSLT), 32'd8, 32'd1, 1'b1);
        step("R3 rd from slt", enc_r(2, 0, 3, FADD), 32'd12, 32'd1, 1'b1);
        step("R6 memory kept", enc_i(OPL, 0, 4, 12), 32'd16, 32'd12, 1'b1);
        step("R6 loaded word", enc_r(4, 0, 5, FOR), 32'd20, 32'd13, 1'b1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule